// File: doc/BRIEF.md
# Stream-to-Video Output Bridge with Lock

This block takes pixels from a valid/ready video stream and turns them into a pixel-rate video output. Its pacing comes from an external video timing source that supplies an active-video window, horizontal sync and vertical sync. In the stream, one sideband bit marks the first pixel of a frame (`s_tuser`) and another marks the last pixel of each line (`s_tlast`). A small FIFO inside the block decouples the two sides. The block also drives a clock enable back to the timing source, so it can freeze that source until the stream is ready and then release it on a frame boundary.

While the block runs, it compares the stream's line and frame markers with the timing. It checks the fall of the active window against the end-of-line flag of the last pixel sent out. It checks each rise of vertical sync against the start-of-frame flag of the next pixel sent out. A separate sticky status bit reports each direction of mismatch. A lock output rises after one whole frame has been checked clean. Any mismatch, or an active cycle that finds the FIFO empty, drops lock. The block then flushes the FIFO, lets the timing source run to its next vertical sync, freezes it there, and waits for a fresh start-of-frame pixel before it tries again.

The whole design runs on one clock. Both sides are paced by qualifiers: valid/ready on the stream side and the clock enable on the timing side.

Top module: `strm2vid_bridge`

## Requirements
- R1: Status bit 3 is set when the timing active window ends before the last pixel sent out carried `s_tlast`, which means the timing line is shorter than the stream line.
- R2: Status bit 4 is set when the pixel just sent out carried `s_tlast` but the timing active window continues, which means the timing line is longer than the stream line.
- R3: Status bit 5 is set when the first pixel sent out after a timing vertical-sync rise does not carry `s_tuser`, which means the timing frame has fewer lines than the stream frame.
- R4: Status bit 6 is set when a pixel carrying `s_tuser` is sent out with no timing vertical-sync rise since the previous frame start, which means the timing frame has more lines than the stream frame.
- R5: `locked` rises, and status bit 0 with it, only after two consecutive frame starts have matched vertical sync with no fault between them. Any fault from R1 to R4, or any underflow, clears it in the following cycle.
- R6: `underflow` is high in any running cycle where `tg_active` is high and the FIFO is empty. Status bit 1 records that an underflow has occurred.
- R7: When no stream data arrives, `s_tready` stays high, `tg_ce` stays low and `locked` stays low.
- R8: `tg_ce` is low after reset until a start-of-frame pixel sits at the FIFO head. After a fault it stays high until the next vertical-sync rise and then goes low again until a new start-of-frame pixel reaches the head.
- R9: `s_tready` is low while the FIFO is full, and no accepted pixel is lost or reordered.
- R10: While the block is not aligned, it accepts stream pixels and discards them until the next pixel carrying `s_tuser`. A stream that starts in the middle of a frame still reaches lock.
- R11: `vid_data` is zero unless `locked` and `vid_active` are both high. While they are, it carries the stream pixels in arrival order, one per active cycle.
- R12: After reset all status bits and `locked` are zero. The fault bits (1, 3, 4, 5, 6) are cleared when each alignment attempt starts, so none of them is set while `locked` is high. Bits 2 and 7 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | PIX_W | Stream pixel |
| s_tvalid | input | 1 | Stream pixel valid |
| s_tready | output | 1 | Block can accept a pixel |
| s_tlast | input | 1 | Pixel is the last of its line |
| s_tuser | input | 1 | Pixel is the first of its frame |
| tg_active | input | 1 | Timing source active-video window |
| tg_hsync | input | 1 | Timing source horizontal sync |
| tg_vsync | input | 1 | Timing source vertical sync |
| tg_ce | output | 1 | Clock enable for the timing source |
| vid_active | output | 1 | Output active video (timing window while running) |
| vid_hsync | output | 1 | Output horizontal sync |
| vid_vsync | output | 1 | Output vertical sync |
| vid_data | output | PIX_W | Output pixel, zero when not locked or blanking |
| locked | output | 1 | Stream and timing sizes agree |
| underflow | output | 1 | Active cycle found the FIFO empty |
| status | output | 8 | Bit 0 locked, 1 underflow seen, 3 line end leading, 4 line end lagging, 5 frame start leading, 6 frame start lagging |

## Verification
The assertions assume that the timing source holds its position while `tg_ce` is low. They also assume that vertical sync lies entirely in blanking, lasts at least two enabled cycles and is never high together with `tg_active`. On the stream side, they assume a frame is a run of whole lines, with `s_tuser` on the first pixel of the frame and `s_tlast` on the last pixel of each line. The bench's timing model advances only on the enable and places vertical sync on a full blanking line ahead of two blanking lines. Its stream model builds frames from per-scenario width and height values, so a size mismatch comes only from those values and never from malformed markers.

// File: rtl/strm2vid_pkg.sv
package strm2vid_pkg;

   localparam int STAT_W = 8;

   localparam int SB_LOCK     = 0;
   localparam int SB_UFLOW    = 1;
   localparam int SB_EOL_LEAD = 3;
   localparam int SB_EOL_LAG  = 4;
   localparam int SB_SOF_LEAD = 5;
   localparam int SB_SOF_LAG  = 6;

   typedef enum logic [1:0] {
      ST_SEEK   = 2'd0,
      ST_RUN    = 2'd1,
      ST_RESYNC = 2'd2
   } align_st_e;

   typedef struct packed {
      logic eol_lead;
      logic eol_lag;
      logic sof_lead;
      logic sof_lag;
      logic uflow;
   } fault_t;

endpackage

// File: rtl/strm2vid_fifo.sv
module strm2vid_fifo #(
   parameter int W     = 26,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);

   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2 = (DEPTH == (1 << AW));

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_n, rp_n;
   logic [AW:0]   cnt;

   generate
      if (POW2) begin : g_pow2_wrap
         assign wp_n = wp + 1'b1;
         assign rp_n = rp + 1'b1;
      end else begin : g_cmp_wrap
         assign wp_n = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_n = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (wr_en) wp <= wp_n;
         if (rd_en) rp <= rp_n;
         case ({wr_en, rd_en})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign rd_data = mem[rp];
   assign empty   = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));

endmodule

// File: rtl/strm2vid_fault_det.sv
module strm2vid_fault_det
   import strm2vid_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   run,
   input  logic   tg_active,
   input  logic   vs_rise,
   input  logic   pop,
   input  logic   head_last,
   input  logic   head_user,
   input  logic   empty,
   output fault_t fault,
   output logic   good_sof
);

   logic act_q;
   logic lastpop_q;
   logic vs_pend;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         act_q     <= 1'b0;
         lastpop_q <= 1'b0;
      end else begin
         act_q <= tg_active;
         if (pop) lastpop_q <= head_last;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vs_pend <= 1'b0;
      end else if (vs_rise) begin
         vs_pend <= 1'b1;
      end else if (good_sof) begin
         vs_pend <= 1'b0;
      end
   end

   assign good_sof = pop && head_user && vs_pend;

   always_comb begin
      fault.eol_lead = run && act_q && !tg_active && !lastpop_q;
      fault.eol_lag  = run && act_q && tg_active && lastpop_q;
      fault.sof_lead = pop && vs_pend && !head_user;
      fault.sof_lag  = pop && !vs_pend && head_user;
      fault.uflow    = run && tg_active && empty;
   end

endmodule

// File: rtl/strm2vid_align_ctrl.sv
module strm2vid_align_ctrl
   import strm2vid_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      accept,
   input  logic      in_user,
   input  logic      head_valid,
   input  logic      head_user,
   input  logic      any_fault,
   input  logic      vs_rise,
   input  logic      good_sof,
   output align_st_e st,
   output logic      armed,
   output logic      flush,
   output logic      enter_run,
   output logic      locked
);

   logic seen_q;

   assign enter_run = (st == ST_SEEK) && armed && head_valid && head_user;
   assign flush     = (st == ST_RUN) && any_fault;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_SEEK;
      end else begin
         case (st)
            ST_SEEK:   if (enter_run) st <= ST_RUN;
            ST_RUN:    if (any_fault) st <= ST_RESYNC;
            ST_RESYNC: if (vs_rise)   st <= ST_SEEK;
            default:   st <= ST_SEEK;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         armed <= 1'b0;
      end else if ((st == ST_SEEK) && accept && in_user) begin
         armed <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || (st != ST_RUN) || any_fault) begin
         seen_q <= 1'b0;
         locked <= 1'b0;
      end else if (good_sof) begin
         seen_q <= 1'b1;
         if (seen_q) locked <= 1'b1;
      end
   end

endmodule

// File: rtl/strm2vid_bridge.sv
module strm2vid_bridge
   import strm2vid_pkg::*;
#(
   parameter int PIX_W      = 24,
   parameter int FIFO_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIX_W-1:0]  s_tdata,
   input  logic              s_tvalid,
   output logic              s_tready,
   input  logic              s_tlast,
   input  logic              s_tuser,
   input  logic              tg_active,
   input  logic              tg_hsync,
   input  logic              tg_vsync,
   output logic              tg_ce,
   output logic              vid_active,
   output logic              vid_hsync,
   output logic              vid_vsync,
   output logic [PIX_W-1:0]  vid_data,
   output logic              locked,
   output logic              underflow,
   output logic [STAT_W-1:0] status
);

   localparam int ENT_W = PIX_W + 2;

   generate
      if (PIX_W < 1) begin : g_bad_width
         $error("strm2vid_bridge: PIX_W must be at least 1");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("strm2vid_bridge: FIFO_DEPTH must be at least 2");
      end
   endgenerate

   align_st_e        st;
   logic             armed, flush, enter_run, run;
   logic             accept, fifo_wr, fifo_rd, fifo_full, fifo_empty;
   logic [ENT_W-1:0] wr_ent, head_ent;
   logic [PIX_W-1:0] head_pix;
   logic             head_user, head_last;
   logic             vs_q, vs_rise;
   fault_t           fault, stk_q;
   logic             any_fault, good_sof;

   assign run      = (st == ST_RUN);
   assign tg_ce    = (st != ST_SEEK);
   assign s_tready = !fifo_full;
   assign accept   = s_tvalid && s_tready;
   assign fifo_wr  = accept && !flush && (armed || ((st == ST_SEEK) && s_tuser));
   assign fifo_rd  = run && tg_active && !fifo_empty;
   assign wr_ent   = {s_tuser, s_tlast, s_tdata};
   assign {head_user, head_last, head_pix} = head_ent;
   assign vs_rise  = tg_ce && tg_vsync && !vs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vs_q <= 1'b0;
      end else if (tg_ce) begin
         vs_q <= tg_vsync;
      end
   end

   strm2vid_fifo #(
      .W     (ENT_W),
      .DEPTH (FIFO_DEPTH)
   ) fifo_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (fifo_wr),
      .wr_data (wr_ent),
      .rd_en   (fifo_rd),
      .rd_data (head_ent),
      .empty   (fifo_empty),
      .full    (fifo_full)
   );

   strm2vid_fault_det det_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tg_active (tg_active),
      .vs_rise   (vs_rise),
      .pop       (fifo_rd),
      .head_last (head_last),
      .head_user (head_user),
      .empty     (fifo_empty),
      .fault     (fault),
      .good_sof  (good_sof)
   );

   assign any_fault = fault.eol_lead | fault.eol_lag | fault.sof_lead |
                      fault.sof_lag  | fault.uflow;

   strm2vid_align_ctrl ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .in_user    (s_tuser),
      .head_valid (!fifo_empty),
      .head_user  (head_user),
      .any_fault  (any_fault),
      .vs_rise    (vs_rise),
      .good_sof   (good_sof),
      .st         (st),
      .armed      (armed),
      .flush      (flush),
      .enter_run  (enter_run),
      .locked     (locked)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || enter_run) begin
         stk_q <= '0;
      end else begin
         stk_q <= stk_q | fault;
      end
   end

   always_comb begin
      status              = '0;
      status[SB_LOCK]     = locked;
      status[SB_UFLOW]    = stk_q.uflow;
      status[SB_EOL_LEAD] = stk_q.eol_lead;
      status[SB_EOL_LAG]  = stk_q.eol_lag;
      status[SB_SOF_LEAD] = stk_q.sof_lead;
      status[SB_SOF_LAG]  = stk_q.sof_lag;
   end

   assign underflow  = fault.uflow;
   assign vid_active = run && tg_active;
   assign vid_hsync  = tg_hsync;
   assign vid_vsync  = tg_vsync;
   assign vid_data   = (locked && vid_active && !fifo_empty) ? head_pix : '0;

endmodule

// File: rtl/strm2vid_bridge_chk.sv
module strm2vid_bridge_chk #(
   parameter int STAT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tg_ce,
   input logic              vid_active,
   input logic              locked,
   input logic              underflow,
   input logic [STAT_W-1:0] status,
   input logic              fifo_wr,
   input logic              fifo_rd,
   input logic              fifo_full,
   input logic              fifo_empty,
   input logic              good_sof
);

   a_r5_lock_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(good_sof));

   a_r5_uflow_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> !locked);

   a_r9_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !fifo_wr);

   a_r6_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> !fifo_rd);

   a_r12_lock_clean: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (status[6:3] == 4'b0000));

   a_r8_active_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
      vid_active |-> tg_ce);

endmodule

bind strm2vid_bridge strm2vid_bridge_chk #(
   .STAT_W (8)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .tg_ce      (tg_ce),
   .vid_active (vid_active),
   .locked     (locked),
   .underflow  (underflow),
   .status     (status),
   .fifo_wr    (fifo_wr),
   .fifo_rd    (fifo_rd),
   .fifo_full  (fifo_full),
   .fifo_empty (fifo_empty),
   .good_sof   (good_sof)
);

// File: tb/strm2vid_bridge_tb_top.sv
`timescale 1ns/1ps
module strm2vid_bridge_tb_top;

   localparam int PW    = 24;
   localparam int DEPTH = 16;
   localparam int GW    = 8;
   localparam int GH    = 4;
   localparam int HT    = GW + 6;
   localparam int VT    = GH + 3;
   localparam int NROWS = 7;
   localparam int RUN_CYC = 3000;

   typedef struct packed {
      logic [7:0] sw;
      logic [7:0] sh;
      logic [7:0] sy0;
      logic [7:0] rate;
      logic       lock;
      logic [5:0] stat;
   } row_t;

   // stat field holds status[6:1]
   localparam row_t ROWS [NROWS] = '{
      '{8'd8,  8'd4, 8'd0, 8'd1, 1'b1, 6'b000000},
      '{8'd10, 8'd4, 8'd0, 8'd1, 1'b0, 6'b000100},
      '{8'd6,  8'd4, 8'd0, 8'd1, 1'b0, 6'b001000},
      '{8'd8,  8'd6, 8'd0, 8'd1, 1'b0, 6'b010000},
      '{8'd8,  8'd3, 8'd0, 8'd1, 1'b0, 6'b100000},
      '{8'd8,  8'd4, 8'd0, 8'd4, 1'b0, 6'b000001},
      '{8'd8,  8'd4, 8'd2, 8'd1, 1'b1, 6'b000000}
   };

   string row_tag [NROWS] = '{"R9 R11 matched sizes", "R1 line end leading",
      "R2 line end lagging", "R3 frame start leading", "R4 frame start lagging",
      "R6 underflow", "R10 mid-frame start"};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [PW-1:0] s_tdata, vid_data;
   logic s_tvalid, s_tready, s_tlast, s_tuser;
   logic tg_active, tg_hsync, tg_vsync, tg_ce;
   logic vid_active, vid_hsync, vid_vsync, locked, underflow;
   logic [7:0] status;

   int sw = 8, sh = 4, sy0 = 0, rate = 1;
   bit src_en = 1'b0;
   int sx, sy, cnt;
   int gx, gy;

   int checks = 0, fails = 0;
   bit mon_en = 1'b0;
   logic [5:0] stat_acc;
   bit lock_ever, trdy_low, uflow_seen, ce_seen;
   int data_bad;

   strm2vid_bridge #(.PIX_W(PW), .FIFO_DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
      .s_tlast(s_tlast), .s_tuser(s_tuser),
      .tg_active(tg_active), .tg_hsync(tg_hsync), .tg_vsync(tg_vsync),
      .tg_ce(tg_ce), .vid_active(vid_active), .vid_hsync(vid_hsync),
      .vid_vsync(vid_vsync), .vid_data(vid_data), .locked(locked),
      .underflow(underflow), .status(status)
   );

   // stream source: pixel value encodes (line+1, column+1)
   assign s_tvalid = src_en && ((cnt % rate) == 0);
   assign s_tdata  = PW'(((sy + 1) << 8) | (sx + 1));
   assign s_tuser  = (sx == 0) && (sy == 0);
   assign s_tlast  = (sx == sw - 1);

   initial forever begin
      @(posedge clk);
      if (!rst_n) begin
         sx <= 0; sy <= sy0; cnt <= 0;
      end else begin
         if (!(s_tvalid && !s_tready)) cnt <= cnt + 1;
         if (s_tvalid && s_tready) begin
            if (sx == sw - 1) begin
               sx <= 0;
               sy <= (sy == sh - 1) ? 0 : sy + 1;
            end else begin
               sx <= sx + 1;
            end
         end
      end
   end

   // timing source model: vsync on line 0, two blanking lines, then GH active lines
   assign tg_active = (gy >= 2) && (gy < 2 + GH) && (gx >= 2) && (gx < 2 + GW);
   assign tg_hsync  = (gx == 0);
   assign tg_vsync  = (gy == 0);

   initial forever begin
      @(posedge clk);
      if (!rst_n) begin
         gx <= 0; gy <= 0;
      end else if (tg_ce) begin
         if (gx == HT - 1) begin
            gx <= 0;
            gy <= (gy == VT - 1) ? 0 : gy + 1;
         end else begin
            gx <= gx + 1;
         end
      end
   end

   // monitor
   initial forever begin
      @(negedge clk);
      if (mon_en) begin
         logic [PW-1:0] exp_px;
         stat_acc  = stat_acc | status[6:1];
         lock_ever = lock_ever | locked;
         if (!s_tready) trdy_low = 1'b1;
         if (underflow) uflow_seen = 1'b1;
         if (tg_ce) ce_seen = 1'b1;
         exp_px = (locked && vid_active) ? PW'(((gy - 1) << 8) | (gx - 1)) : '0;
         if (vid_data !== exp_px) data_bad++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_acc();
      stat_acc = '0; lock_ever = 0; trdy_low = 0; uflow_seen = 0;
      ce_seen = 0; data_bad = 0;
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      // reset state
      src_en = 1'b0;
      do_reset();
      @(negedge clk);
      chk(s_tready == 1'b1, "R7 tready after reset", s_tready, 1);
      chk(tg_ce == 1'b0, "R8 enable low after reset", tg_ce, 0);
      chk(locked == 1'b0, "R5 unlocked after reset", locked, 0);
      chk(status == 8'h00, "R12 status zero after reset", status, 0);
      chk(vid_data == '0, "R11 data zero after reset", vid_data, 0);

      // no input data
      clear_acc();
      mon_en = 1'b1;
      repeat (1000) @(posedge clk);
      @(negedge clk) mon_en = 1'b0;
      chk(!ce_seen, "R7 enable held low with no data", ce_seen, 0);
      chk(!trdy_low, "R7 tready held high with no data", trdy_low, 0);
      chk(!lock_ever, "R7 no lock with no data", lock_ever, 0);

      // scenario table
      for (int i = 0; i < NROWS; i++) begin
         sw = ROWS[i].sw; sh = ROWS[i].sh; sy0 = ROWS[i].sy0; rate = ROWS[i].rate;
         src_en = 1'b0;
         do_reset();
         clear_acc();
         src_en = 1'b1;
         mon_en = 1'b1;
         repeat (RUN_CYC) @(posedge clk);
         @(negedge clk) mon_en = 1'b0;
         chk(lock_ever == ROWS[i].lock, {row_tag[i], " R5 lock"}, lock_ever, ROWS[i].lock);
         chk(stat_acc == ROWS[i].stat, {row_tag[i], " status[6:1]"}, stat_acc, ROWS[i].stat);
         chk(data_bad == 0, {row_tag[i], " R11 output data"}, data_bad, 0);
         if (i == 0) begin
            chk(trdy_low, "R9 backpressure when full", trdy_low, 1);
            chk(locked && status[6:3] == 4'b0000, "R12 locked with clean status",
                {status[6:3], locked}, 1);
         end
         if (i == 5) chk(uflow_seen, "R6 underflow port", uflow_seen, 1);
      end

      // reset while locked
      sw = 8; sh = 4; sy0 = 0; rate = 1;
      src_en = 1'b0;
      do_reset();
      src_en = 1'b1;
      repeat (RUN_CYC) @(posedge clk);
      @(negedge clk);
      chk(locked == 1'b1, "R5 locked before reset", locked, 1);
      do_reset();
      @(negedge clk);
      chk(locked == 1'b0 && status == 8'h00, "R12 reset clears lock and status", status, 0);
      chk(tg_ce == 1'b0, "R8 enable low after second reset", tg_ce, 0);

      summary();
      $finish;
   end

endmodule